// File: doc/BRIEF.md
# Direct-Mapped Line-Refill Cache

This block is a direct-mapped cache for a byte-addressed 32-bit memory, built so that one design serves as either the instruction cache or the data cache. Tag/valid storage and word storage are held in separate arrays. Both are indexed from the same incoming address. A read is requested with a one-cycle strobe. On the next clock the block presents the registered word together with a hit or miss verdict. The miss output is only a stall request to the surrounding pipeline.

A line holds eight 32-bit words. A line is refilled by an external filler, which streams the eight words one per cycle with the write strobe high. The filler steps the address by 4 for each word. The last-word strobe is raised together with the eighth word. That strobe records the new tag and marks the line valid. From the first refill word of a line until that final word, the line reads as invalid.

Top module: `dm_fill_cache`

## Requirements
- R1: A read strobe in cycle t produces exactly one of hit or miss in cycle t+1, with the word on the read data output in that cycle. In any cycle that does not follow a read strobe, hit and miss are both low.
- R2: Hit is asserted only when the stored tag of the indexed line equals the address tag and that line's valid bit is set. Otherwise miss is asserted. Hit and miss are never high together.
- R3: The address is decoded as word offset = bits [4:2], line index = bits [10:5] (64 lines) and tag = bits [31:11]. Bits [1:0] have no effect on any read or write.
- R4: In a cycle with the write strobe high, the data input is stored in the word slot selected by the address offset and index. The eighth word of a refill is written with the last-word strobe also high. That strobe sets the line valid with the address tag, so a following read of any word of that line hits and returns the stored word.
- R5: A write strobe without the last-word strobe clears the valid bit of the addressed line. Reads of that line miss until a write with the last-word strobe completes it.
- R6: The last-word strobe while the write strobe is low has no effect on tags, valid bits or data.
- R7: Reset clears every valid bit, so every read after reset misses. Hit and miss are low during reset.
- R8: When a read and a write fall in the same cycle, the read reports the word, tag and valid bit as they stood before that clock edge.
- R9: Completing a refill of a line under a new tag evicts the old tag: reads with the old tag miss, and reads with the new tag hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 32 | Byte address for a read or for a refill word |
| rd_en_i | input | 1 | Read strobe; the result appears in the next cycle |
| wr_en_i | input | 1 | Refill word strobe, high with each incoming word |
| fill_last_i | input | 1 | High with the eighth refill word; validates the line |
| wr_data_i | input | 32 | Refill word |
| rd_data_o | output | 32 | Registered read word |
| hit_o | output | 1 | Read in the previous cycle found a valid matching line |
| miss_o | output | 1 | Read in the previous cycle did not hit; stall request |

## Verification
A lookup and a refill word can land in the same cycle. This includes the refill word that carries the last-word strobe, and in that case the line's valid bit and the read port's view of it change at the same edge. The bench provokes both cases at the same word address. For the opening word it expects a hit with the old word, followed by misses. For the closing word it expects a miss, followed by a hit with the new word, because the read sees the state before that edge. A second crossing is the last-word strobe raised with no write strobe. The bench judges it by reading the line under its old tag, which must still hit, and under the other tag, which must still miss.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_OFF_W  = 3;
    localparam int unsigned DEF_IDX_W  = 6;

    // action a refill cycle takes on the tag/valid array
    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_OPEN  = 2'd1,
        FILL_CLOSE = 2'd2
    } fill_op_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 3,
    parameter int unsigned IDX_W  = 6,
    localparam int unsigned TAG_W = ADDR_W - 2 - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:2] word_addr_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [OFF_W-1:0]  off_o
);
    always_comb begin
        off_o = word_addr_i[OFF_W+1:2];
        idx_o = word_addr_i[IDX_W+OFF_W+1:OFF_W+2];
        tag_o = word_addr_i[ADDR_W-1:IDX_W+OFF_W+2];
    end
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
#(
    parameter int unsigned TAG_W = 21,
    parameter int unsigned IDX_W = 6,
    localparam int unsigned LINES = 1 << IDX_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  fill_op_e         op_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_vld_o,
    output logic [TAG_W-1:0] rd_tag_o
);
    typedef struct packed {
        logic [LINES-1:0] vld;
        logic             rd_vld;
    } vstate_t;

    vstate_t          st_d, st_q;
    logic [TAG_W-1:0] tags_q [LINES];
    logic [TAG_W-1:0] rd_tag_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.rd_vld = st_q.vld[rd_idx_i];
        end
        case (op_i)
            FILL_OPEN:  st_d.vld[wr_idx_i] = 1'b0;
            FILL_CLOSE: st_d.vld[wr_idx_i] = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // tag array: read returns the value held before this edge
    always_ff @(posedge clk_i) begin
        if (rd_en_i) begin
            rd_tag_q <= tags_q[rd_idx_i];
        end
        if (op_i == FILL_CLOSE) begin
            tags_q[wr_idx_i] <= wr_tag_i;
        end
    end

    assign rd_vld_o = st_q.rd_vld;
    assign rd_tag_o = rd_tag_q;
endmodule

// File: rtl/dmc_word_store.sv
module dmc_word_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFF_W  = 3,
    parameter int unsigned IDX_W  = 6,
    localparam int unsigned SLOT_W = IDX_W + OFF_W,
    localparam int unsigned SLOTS  = 1 << SLOT_W
) (
    input  logic              clk_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] mem_q [SLOTS];
    logic [DATA_W-1:0] rd_data_d, rd_data_q;
    logic [SLOT_W-1:0] rd_slot, wr_slot;

    always_comb begin
        rd_slot   = {rd_idx_i, rd_off_i};
        wr_slot   = {wr_idx_i, wr_off_i};
        rd_data_d = rd_en_i ? mem_q[rd_slot] : rd_data_q;
    end

    always_ff @(posedge clk_i) begin
        rd_data_q <= rd_data_d;
        if (wr_en_i) begin
            mem_q[wr_slot] <= wr_data_i;
        end
    end

    assign rd_data_o = rd_data_q;
endmodule

// File: rtl/dmc_lookup.sv
module dmc_lookup #(
    parameter int unsigned TAG_W = 21
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rd_en_i,
    input  logic [TAG_W-1:0] want_tag_i,
    input  logic             line_vld_i,
    input  logic [TAG_W-1:0] line_tag_i,
    output logic             hit_o,
    output logic             miss_o
);
    typedef struct packed {
        logic             pend;
        logic [TAG_W-1:0] want;
    } look_t;

    look_t lk_d, lk_q;
    logic  match;

    always_comb begin
        lk_d      = lk_q;
        lk_d.pend = rd_en_i;
        if (rd_en_i) begin
            lk_d.want = want_tag_i;
        end
        match  = line_vld_i && (line_tag_i == lk_q.want);
        hit_o  = lk_q.pend && match;
        miss_o = lk_q.pend && !match;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end
endmodule

// File: rtl/dm_fill_cache.sv
module dm_fill_cache
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned IDX_W  = DEF_IDX_W,
    localparam int unsigned TAG_W = ADDR_W - 2 - OFF_W - IDX_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic              fill_last_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              hit_o,
    output logic              miss_o
);
    logic [TAG_W-1:0] a_tag, line_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    logic             line_vld;
    fill_op_e         op;

    dmc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .word_addr_i (addr_i[ADDR_W-1:2]),
        .tag_o       (a_tag),
        .idx_o       (a_idx),
        .off_o       (a_off)
    );

    always_comb begin
        if (!wr_en_i)        op = FILL_IDLE;
        else if (fill_last_i) op = FILL_CLOSE;
        else                  op = FILL_OPEN;
    end

    dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .wr_idx_i (a_idx),
        .wr_tag_i (a_tag),
        .rd_en_i  (rd_en_i),
        .rd_idx_i (a_idx),
        .rd_vld_o (line_vld),
        .rd_tag_o (line_tag)
    );

    dmc_word_store #(.DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_words (
        .clk_i     (clk_i),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (a_idx),
        .wr_off_i  (a_off),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_idx_i  (a_idx),
        .rd_off_i  (a_off),
        .rd_data_o (rd_data_o)
    );

    dmc_lookup #(.TAG_W(TAG_W)) u_look (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rd_en_i    (rd_en_i),
        .want_tag_i (a_tag),
        .line_vld_i (line_vld),
        .line_tag_i (line_tag),
        .hit_o      (hit_o),
        .miss_o     (miss_o)
    );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFF_W  = 3,
    parameter int unsigned IDX_W  = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic              fill_last_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              hit_o,
    input logic              miss_o
);
    localparam int unsigned IDX_LO = OFF_W + 2;
    localparam int unsigned IDX_HI = IDX_W + OFF_W + 1;

    logic              open_q, close_q;
    logic [ADDR_W-1:0] wa_q;
    logic [DATA_W-1:0] wd_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            open_q  <= 1'b0;
            close_q <= 1'b0;
            wa_q    <= '0;
            wd_q    <= '0;
        end else begin
            open_q  <= wr_en_i && !fill_last_i;
            close_q <= wr_en_i && fill_last_i;
            wa_q    <= addr_i;
            wd_q    <= wr_data_i;
        end
    end

    // R1: every read strobe is answered next cycle
    a_r1_answer: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i |=> (hit_o || miss_o));

    // R1: no verdict without a preceding read strobe
    a_r1_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> (!hit_o && !miss_o));

    // R2: verdicts are exclusive
    a_r2_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hit_o && miss_o));

    // R5: a line opened for refill reads as a miss
    a_r5_open_miss: assert property (@(posedge clk_i) disable iff (rst_i)
        (open_q && rd_en_i && addr_i[IDX_HI:IDX_LO] == wa_q[IDX_HI:IDX_LO]) |=> miss_o);

    // R4: the closing word is readable as a hit right after
    a_r4_close_hit: assert property (@(posedge clk_i) disable iff (rst_i)
        (close_q && rd_en_i && addr_i[ADDR_W-1:2] == wa_q[ADDR_W-1:2])
            |=> (hit_o && rd_data_o == $past(wd_q)));
endmodule

bind dm_fill_cache dmc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .addr_i      (addr_i),
    .rd_en_i     (rd_en_i),
    .wr_en_i     (wr_en_i),
    .fill_last_i (fill_last_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .hit_o       (hit_o),
    .miss_o      (miss_o)
);

// File: tb/dm_fill_cache_test.sv
`timescale 1ns/1ps
module dm_fill_cache_test;
    localparam int LINES = 64;
    localparam int WPL   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0, last = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        hit, miss;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dm_fill_cache uut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .rd_en_i(rd_en),
        .wr_en_i(wr_en), .fill_last_i(last), .wr_data_i(wdata),
        .rd_data_o(rdata), .hit_o(hit), .miss_o(miss)
    );

    function automatic logic [31:0] mk(input logic [20:0] tg, input int idx, input int off);
        return {tg, idx[5:0], off[2:0], 2'b00};
    endfunction

    function automatic logic [31:0] pat(input logic [31:0] a, input logic [31:0] salt);
        return (a * 32'h9E37_79B1) ^ salt;
    endfunction

    task automatic cyc(input bit r, input bit w, input bit l,
                       input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        rd_en = r; wr_en = w; last = l; addr = a; wdata = d;
        @(negedge clk);
        rd_en = 0; wr_en = 0; last = 0;
    endtask

    task automatic expect_rd(input string req, input bit eh, input logic [31:0] ed, input bit chk_d);
        checks++;
        if (hit !== eh || miss !== !eh || (chk_d && rdata !== ed)) begin
            errors++;
            $display("FAIL %s: hit=%b miss=%b data=%h expected hit=%b miss=%b data=%h",
                     req, hit, miss, rdata, eh, !eh, ed);
        end
    endtask

    task automatic fill_line(input logic [20:0] tg, input int idx, input logic [31:0] salt);
        for (int o = 0; o < WPL; o++) begin
            cyc(0, 1, o == WPL-1, mk(tg, idx, o), pat(mk(tg, idx, o), salt));
        end
    endtask

    localparam logic [20:0] T0 = 21'h0_0A5;
    localparam logic [20:0] T1 = 21'h1_5A3;
    localparam logic [31:0] S0 = 32'h1234_5678;
    localparam logic [31:0] S1 = 32'hCAFE_0F0F;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (hit !== 1'b0 || miss !== 1'b0) begin
            errors++;
            $display("FAIL R7 reset: hit=%b miss=%b expected 0 0", hit, miss);
        end
        rst = 1'b0;

        // R7: all lines invalid after reset
        for (int i = 0; i < LINES; i++) begin
            cyc(1, 0, 0, mk(T0, i, i % WPL), 0);
            expect_rd("R7 miss after reset", 0, 0, 0);
        end

        // R1: idle cycle after a read gives no verdict
        cyc(0, 0, 0, mk(T0, 0, 0), 0);
        checks++;
        if (hit !== 1'b0 || miss !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle: hit=%b miss=%b expected 0 0", hit, miss);
        end

        // R4/R3: fill every line, then read every word with low bits varied
        for (int i = 0; i < LINES; i++) fill_line(T0, i, S0);
        for (int i = 0; i < LINES; i++) begin
            for (int o = 0; o < WPL; o++) begin
                cyc(1, 0, 0, mk(T0, i, o) | ((i + o) % 4), 0);
                expect_rd("R4 R3 hit sweep", 1, pat(mk(T0, i, o), S0), 1);
            end
        end

        // R2: wrong tag misses on a valid line
        cyc(1, 0, 0, mk(T1, 3, 1), 0);
        expect_rd("R2 tag mismatch", 0, 0, 0);

        // R9: refill line 5 under T1
        fill_line(T1, 5, S1);
        cyc(1, 0, 0, mk(T0, 5, 2), 0);
        expect_rd("R9 old tag evicted", 0, 0, 0);
        cyc(1, 0, 0, mk(T1, 5, 2), 0);
        expect_rd("R9 new tag hit", 1, pat(mk(T1, 5, 2), S1), 1);

        // R5: partial refill of line 9
        for (int o = 0; o < 3; o++) cyc(0, 1, 0, mk(T1, 9, o), pat(mk(T1, 9, o), S1));
        cyc(1, 0, 0, mk(T0, 9, 6), 0);
        expect_rd("R5 old tag during fill", 0, 0, 0);
        cyc(1, 0, 0, mk(T1, 9, 0), 0);
        expect_rd("R5 new tag during fill", 0, 0, 0);
        for (int o = 3; o < WPL; o++) cyc(0, 1, o == WPL-1, mk(T1, 9, o), pat(mk(T1, 9, o), S1));
        cyc(1, 0, 0, mk(T1, 9, 0), 0);
        expect_rd("R5 R4 after completion", 1, pat(mk(T1, 9, 0), S1), 1);

        // R6: last-word strobe alone does nothing
        cyc(0, 0, 1, mk(T1, 12, 7), 32'hDEAD_BEEF);
        cyc(1, 0, 0, mk(T0, 12, 7), 0);
        expect_rd("R6 old tag kept", 1, pat(mk(T0, 12, 7), S0), 1);
        cyc(1, 0, 0, mk(T1, 12, 7), 0);
        expect_rd("R6 no tag change", 0, 0, 0);

        // R8: read and opening write in the same cycle
        cyc(1, 1, 0, mk(T0, 20, 2), 32'h0BAD_F00D);
        expect_rd("R8 read beside opening write", 1, pat(mk(T0, 20, 2), S0), 1);
        cyc(1, 0, 0, mk(T0, 20, 2), 0);
        expect_rd("R5 after opening write", 0, 0, 0);
        for (int o = 0; o < WPL-1; o++) cyc(0, 1, 0, mk(T0, 20, o), pat(mk(T0, 20, o), S1));
        cyc(1, 1, 1, mk(T0, 20, 7), pat(mk(T0, 20, 7), S1));
        expect_rd("R8 read beside closing write", 0, 0, 0);
        cyc(1, 0, 0, mk(T0, 20, 7), 0);
        expect_rd("R8 after closing write", 1, pat(mk(T0, 20, 7), S1), 1);
        cyc(1, 0, 0, mk(T0, 20, 2), 0);
        expect_rd("R4 refreshed word", 1, pat(mk(T0, 20, 2), S1), 1);

        // R7: reset again invalidates everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cyc(1, 0, 0, mk(T0, 0, 0), 0);
        expect_rd("R7 reset clears valid", 0, 0, 0);

        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done=0 expected 1");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule